// File: doc/BRIEF.md
# Two-Wire Slave With 16-Byte Store

This block is the slave side of a two-wire serial bus. It holds a 16-entry by 8-bit store in flip-flops. It does not see the raw bus pins. A conditioning stage ahead of it delivers one-cycle event strobes: start, stop, clock rising and clock falling. It also delivers the filtered data level. The block answers by asserting an open-drain pull-low request on the data line. It decodes the control byte that follows a start and supports four operations: byte write, current-address read, random read and sequential read.

A committed write starts a self-timed programming interval. The interval is counted in system clocks and is set by a parameter. For the whole interval the block stays silent on the bus and ignores every control byte. A master can therefore poll the block until it acknowledges again. A supply-good input decides whether a pending write may commit. Only the low four bits of the word address are used. The three chip-select bits of the control byte are not compared.

Top module: `i2c_eeprom16`

## Requirements
- R1: The store has 16 independent 8-bit locations. A value written to any location is read back unchanged.
- R2: The slave acknowledges a control byte only when its upper four bits are 1010. Bits 3..1 are ignored. Bit 0 selects read when 1 and write when 0. Any other upper nibble gets no acknowledge.
- R3: While `busy` is high, the slave acknowledges no control byte. `busy` stays high for exactly `WCYC` clock cycles after the stop that commits a write.
- R4: In a write, the byte after the control byte is the word address. Its low four bits load the address pointer and its upper four bits are ignored.
- R5: The sequence control byte, address, data byte, then stop commits the data byte. Each of those three bytes is acknowledged. The stop starts the busy interval.
- R6: After a byte write, the pointer still holds the written location, so a current-address read returns the byte just written.
- R7: A stop that arrives before a complete data byte aborts the command. In that case nothing is written and `busy` stays low. This holds even when earlier complete data bytes were sent.
- R8: When more than one data byte arrives before the stop, only the last complete byte is committed.
- R9: Each byte sent to the master increments the pointer by one, wrapping from 15 to 0. A current-address read after reading n returns n+1.
- R10: A random read loads the pointer with a write-mode address byte, then uses a repeated start and a read control byte, and returns the addressed byte.
- R11: In a read, a master acknowledge makes the slave send the next byte. A master not-acknowledge makes the slave release the data line.
- R12: While `supply_ok` is low at the committing stop, no location is modified and `busy` stays low.
- R13: The pull-low request changes only in the cycle after a clock-falling, start or stop strobe. It is released whenever the slave is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_evt | input | 1 | One-cycle strobe for a start or repeated start |
| stop_evt | input | 1 | One-cycle strobe for a stop |
| scl_rise | input | 1 | One-cycle strobe on a rising serial clock |
| scl_fall | input | 1 | One-cycle strobe on a falling serial clock |
| sda_in | input | 1 | Filtered level of the serial data line |
| supply_ok | input | 1 | High when the supply is good enough for writing |
| sda_pull | output | 1 | Request to pull the data line low |
| busy | output | 1 | High during the self-timed write interval |

## Verification
Some rules are checked by assertions on every cycle. The slave never pulls the line while busy or idle. The pull request moves only after a falling clock or a bus condition. The busy interval can begin only from a stop, and it never begins while the supply is low. Other behaviour can be seen only through the bench's bus transactions. These include the device-code decode across all sixteen nibbles, and the masking of the address nibble. They also include the pointer holding after a write and advancing with wrap on reads, the abort and last-byte rules for write data, and the exact length of the busy interval.

// File: rtl/i2c_eeprom16.sv
module i2c_eeprom16 #(
  parameter int AW = 4,
  parameter int WCYC = 400000,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_evt,
  input  logic stop_evt,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic sda_in,
  input  logic supply_ok,
  output logic sda_pull,
  output logic busy
);
  localparam int DEPTH = 1 << AW;
  localparam int CW = $clog2(WCYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_ADDR, S_WDAT, S_READ} st_t;

  st_t st;
  logic [3:0] cnt;
  logic [7:0] rx, tx, wbuf;
  logic [7:0] mem [DEPTH];
  logic [AW-1:0] ptr;
  logic have, mack;
  logic [CW-1:0] bcnt;

  assign busy = bcnt != '0;

  wire commit = stop_evt && st == S_WDAT && have && supply_ok;
  wire ack_now = (st == S_CTRL) ? (rx[7:4] == DEV_CODE && !busy) : 1'b1;
  wire [2:0] tx_idx = 3'(4'd7 - cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      rx <= '0;
      tx <= '0;
      wbuf <= '0;
      ptr <= '0;
      have <= 1'b0;
      mack <= 1'b0;
      bcnt <= '0;
      sda_pull <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (busy) bcnt <= bcnt - CW'(1);
      if (start_evt) begin
        st <= S_CTRL;
        cnt <= '0;
        sda_pull <= 1'b0;
      end else if (stop_evt) begin
        st <= S_IDLE;
        cnt <= '0;
        sda_pull <= 1'b0;
        if (commit) begin
          mem[ptr] <= wbuf;
          bcnt <= CW'(WCYC);
        end
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          if (cnt != 4'd9) cnt <= cnt + 4'd1;
          if (cnt < 4'd8) rx <= {rx[6:0], sda_in};
          if (st == S_WDAT && cnt == 4'd0) have <= 1'b0;
          if (st == S_WDAT && cnt == 4'd7) begin
            wbuf <= {rx[6:0], sda_in};
            have <= 1'b1;
          end
          if (st == S_READ && cnt == 4'd8) mack <= !sda_in;
        end else if (scl_fall) begin
          if (st == S_READ) begin
            if (cnt == 4'd9) begin
              if (mack) begin
                tx <= mem[ptr];
                ptr <= ptr + AW'(1);
                sda_pull <= !mem[ptr][7];
                cnt <= '0;
              end else begin
                st <= S_IDLE;
                sda_pull <= 1'b0;
              end
            end else if (cnt == 4'd8) sda_pull <= 1'b0;
            else if (cnt != 4'd0) sda_pull <= !tx[tx_idx];
          end else if (cnt == 4'd8) begin
            sda_pull <= ack_now;
          end else if (cnt == 4'd9) begin
            sda_pull <= 1'b0;
            cnt <= '0;
            case (st)
              S_CTRL:
                if (!sda_pull) st <= S_IDLE;
                else if (rx[0]) begin
                  st <= S_READ;
                  tx <= mem[ptr];
                  ptr <= ptr + AW'(1);
                  sda_pull <= !mem[ptr][7];
                end else st <= S_ADDR;
              S_ADDR: begin
                ptr <= rx[AW-1:0];
                have <= 1'b0;
                st <= S_WDAT;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  AST_BUSY_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull); // R3
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> !sda_pull); // R13
  AST_PULL_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> $past(scl_fall || start_evt || stop_evt)); // R13
  AST_LOW_SUPPLY_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok && !busy) |=> !busy); // R12
  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt)); // R5
endmodule

// File: tb/tb_i2c_eeprom16.sv
module tb_i2c_eeprom16;
  localparam int CLK_PERIOD = 10;
  localparam int WCYC = 200;

  logic clk = 0, rst_n = 0;
  logic start_evt = 0, stop_evt = 0, scl_rise = 0, scl_fall = 0;
  logic sda_drv = 1, supply_ok = 1;
  logic sda_pull, busy;
  wire sda_in = sda_drv & ~sda_pull;
  int checks = 0, errors = 0, cyc = 0;

  i2c_eeprom16 #(.AW(4), .WCYC(WCYC), .DEV_CODE(4'b1010)) dut (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
    .supply_ok(supply_ok), .sda_pull(sda_pull), .busy(busy));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] dval(input int a);
    return 8'(a * 29 + 7);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe_start(); start_evt = 1; @(negedge clk); start_evt = 0; @(negedge clk); endtask
  task automatic strobe_stop();  stop_evt = 1;  @(negedge clk); stop_evt = 0;  @(negedge clk); endtask

  task automatic do_bit(input logic b, output logic pulled);
    pulled = sda_pull;
    sda_drv = b;
    scl_rise = 1; @(negedge clk); scl_rise = 0; @(negedge clk);
    scl_fall = 1; @(negedge clk); scl_fall = 0; @(negedge clk);
    sda_drv = 1;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic p;
    for (int i = 7; i >= 0; i--) do_bit(v[i], p);
    do_bit(1'b1, p);
    ack = p;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    logic p;
    for (int i = 7; i >= 0; i--) begin do_bit(1'b1, p); v[i] = !p; end
    do_bit(!mack, p);
  endtask

  task automatic write_cmd(input logic [7:0] abyte, input logic [7:0] d, output bit all_ack);
    logic a0, a1, a2;
    strobe_start();
    send_byte(8'hA4, a0);
    send_byte(abyte, a1);
    send_byte(d, a2);
    strobe_stop();
    all_ack = a0 && a1 && a2;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * WCYC && busy; i++) @(negedge clk);
  endtask

  task automatic rand_read(input int a, output logic [7:0] v);
    logic k;
    strobe_start();
    send_byte(8'hA0, k);
    send_byte(8'(a), k);
    strobe_start();
    send_byte(8'hAF, k);
    recv_byte(1'b0, v);
    strobe_stop();
  endtask

  task automatic cur_read(output logic [7:0] v);
    logic k;
    strobe_start();
    send_byte(8'hA1, k);
    recv_byte(1'b0, v);
    strobe_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic k;
    logic [7:0] v;
    bit ok;
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(sda_pull == 0 && busy == 0, "R13 reset", {sda_pull, busy}, 0);

    // R2: sweep every upper nibble, chip-select bits varied
    for (int n = 0; n < 16; n++) begin
      strobe_start();
      send_byte({4'(n), 3'(n), 1'b0}, k);
      chk(k == (n == 10), "R2 device code", k, n == 10);
      strobe_stop();
      chk(busy == 0, "R7 stop after control byte", busy, 0);
    end

    // R1 R4 R5 R6 R3: write every location, upper address nibble noisy
    for (int a = 0; a < 16; a++) begin
      write_cmd({4'(a * 3 + 5), 4'(a)}, dval(a), ok);
      chk(ok, "R5 write acks", ok, 1);
      chk(busy == 1, "R5 busy after stop", busy, 1);
      if (a == 0) begin
        c0 = cyc;
        strobe_start();
        send_byte(8'hA0, k);
        chk(k == 0, "R3 no ack to write poll", k, 0);
        strobe_start();
        send_byte(8'hA1, k);
        chk(k == 0, "R3 no ack to read poll", k, 0);
        strobe_stop();
        wait_idle();
        // stop task returns one cycle after busy rises
        chk(cyc - c0 == WCYC - 1, "R3 busy length", cyc - c0, WCYC - 1);
      end else wait_idle();
      cur_read(v);
      chk(v == dval(a), "R6 current read after write", v, dval(a));
    end

    for (int a = 0; a < 16; a++) begin
      rand_read(a + 16 * (a % 3), v);
      chk(v == dval(a), "R1 R4 R10 random read", v, dval(a));
    end

    // R9 R11: sequential read with wrap
    strobe_start();
    send_byte(8'hA0, k);
    send_byte(8'd14, k);
    strobe_start();
    send_byte(8'hA1, k);
    for (int j = 0; j < 5; j++) begin
      recv_byte(j != 4, v);
      chk(v == dval((14 + j) % 16), "R9 R11 sequential wrap", v, dval((14 + j) % 16));
    end
    chk(sda_pull == 0, "R11 release after master nack", sda_pull, 0);
    strobe_stop();
    chk(sda_pull == 0, "R13 idle released", sda_pull, 0);
    cur_read(v);
    chk(v == dval(3), "R9 pointer advanced", v, dval(3));

    // R7: partial second data byte aborts
    strobe_start();
    send_byte(8'hA0, k);
    send_byte(8'd3, k);
    send_byte(8'hAA, k);
    for (int i = 0; i < 5; i++) do_bit(1'b1, k);
    strobe_stop();
    chk(busy == 0, "R7 abort no busy", busy, 0);
    rand_read(3, v);
    chk(v == dval(3), "R7 abort keeps data", v, dval(3));
    strobe_start();
    send_byte(8'hA0, k);
    send_byte(8'd3, k);
    for (int i = 0; i < 4; i++) do_bit(1'b0, k);
    strobe_stop();
    chk(busy == 0, "R7 partial first byte", busy, 0);

    // R8: several data bytes, last one wins
    strobe_start();
    send_byte(8'hA0, k);
    send_byte(8'd4, k);
    send_byte(8'h11, k);
    send_byte(8'h22, k);
    send_byte(8'h33, k);
    strobe_stop();
    chk(busy == 1, "R8 commit started", busy, 1);
    wait_idle();
    rand_read(4, v);
    chk(v == 8'h33, "R8 last byte committed", v, 8'h33);

    // R12: low supply blocks the write
    supply_ok = 0;
    write_cmd(8'd5, 8'h99, ok);
    chk(busy == 0, "R12 no busy on low supply", busy, 0);
    supply_ok = 1;
    rand_read(5, v);
    chk(v == dval(5), "R12 location unchanged", v, dval(5));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule